// File: doc/BRIEF.md
# Key Matrix Scanner with Interrupt

The block watches a 5-row by 6-column key matrix whose column returns are pulled up and go low when a key connects them to a row driven low. At rest it drives every row low, so any pressed key pulls its column low. On each scan tick it compares the AND of all columns with the value from the previous idle tick. A difference means a key was pressed or released. That event starts continuous scanning: one row at a time is driven low, in ascending order, and the six columns are captured into a 30-bit key map.

When the first full pass over all rows is done, the interrupt output goes high. It stays high through later passes until the host selects keyscan-stop, which arrives as a one-cycle strobe from the serial command decoder. Stop returns all rows to low and puts the block back in idle. While keyscan read mode is selected, the shared serial data pin is an output and carries a snapshot of the key map, one bit per rising serial clock.

Top module: `key_scan_top`

## Requirements
- R1: After reset, row_o is all zeros, and irq_o, sdata_oe_o and sdata_o are 0.
- R2: While idle, row_o stays all zeros, and ticks with an unchanged column AND do not start a scan.
- R3: A press or a release starts scanning. Either one changes the AND of all columns relative to the previous idle tick. On such a tick, row_o becomes 5'b11110 (row 0 low) after that clock edge.
- R4: While scanning, exactly one row is low at a time, in the order 0,1,2,3,4 and then back to 0. Each row lasts HOLD_TICKS ticks (default 2). Without a tick or a stop, row_o does not change.
- R5: On the last tick of a row, each column is sampled. Key-map bit r*6+c is set to 1 when column c is low, meaning the key at row r and column c is pressed. Otherwise the bit is set to 0.
- R6: irq_o rises after the clock edge of the 5*HOLD_TICKS-th tick following the start tick. It stays high through later passes until a stop.
- R7: A stop_i strobe clears irq_o and returns row_o to all zeros and the block to idle after the next clock edge. Stop overrides a simultaneous tick.
- R8: sdata_oe_o is 1 exactly while read_i is 1.
- R9: After the clock edge where read_i rises, sdata_o shows bit 0 of a snapshot of the key map. Each rising edge of sclk_i while read_i is high advances to the next bit. After bit 29, sdata_o reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Scan tick enable |
| stop_i | input | 1 | Keyscan-stop mode strobe |
| read_i | input | 1 | Keyscan read mode selected |
| sclk_i | input | 1 | Serial clock level |
| col_ni | input | 6 | Column returns, active low |
| row_o | output | 5 | Row drives; a low row is selected |
| irq_o | output | 1 | Interrupt to host |
| sdata_o | output | 1 | Serial key-map data |
| sdata_oe_o | output | 1 | Output enable for the shared data pin |

## Verification
The assertions check, on every cycle, four things:
- While the interrupt is high, exactly one row is low.
- The interrupt holds until a stop.
- A stop clears the rows and the interrupt.
- Rows move only on ticks, and a scan always leaves idle at row 0.

Only the bench scenarios can show the rest, because each needs a modelled matrix and host:
- Presses and releases each start a scan.
- The interrupt arrives on exactly the 10th tick.
- The captured map places each key at bit r*6+c without leakage between rows.
- The serial read-out yields that map in order and then zeros.

// File: rtl/key_scan_pkg.sv
package key_scan_pkg;
  parameter int unsigned KS_ROWS = 5;
  parameter int unsigned KS_COLS = 6;
  parameter int unsigned KS_HOLD = 2;

  typedef enum logic {
    KS_IDLE = 1'b0,
    KS_SCAN = 1'b1
  } ks_state_e;
endpackage

// File: rtl/key_change_det.sv
module key_change_det #(
  parameter int unsigned COLS = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            idle_i,
  input  logic [COLS-1:0] col_ni,
  output logic            start_o
);
  logic all_high;
  logic prev_q;

  assign all_high = &col_ni;

  // reset value 1: no key pressed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                prev_q <= 1'b1;
    else if (idle_i && tick_i)  prev_q <= all_high;
  end

  assign start_o = idle_i && tick_i && (all_high != prev_q);
endmodule

// File: rtl/key_scan_seq.sv
module key_scan_seq
  import key_scan_pkg::*;
#(
  parameter int unsigned ROWS       = 5,
  parameter int unsigned COLS       = 6,
  parameter int unsigned HOLD_TICKS = 2,
  localparam int unsigned KEYS      = ROWS * COLS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic [COLS-1:0] col_ni,
  output logic [ROWS-1:0] row_o,
  output logic [KEYS-1:0] map_o,
  output logic            irq_o,
  output logic            idle_o
);
  localparam int unsigned RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int unsigned HW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [RW-1:0] ROW_LAST   = RW'(ROWS - 1);
  localparam logic [HW-1:0] DWELL_LAST = HW'(HOLD_TICKS - 1);

  ks_state_e       state_q;
  logic [RW-1:0]   row_q;
  logic [HW-1:0]   dwell_q;
  logic [KEYS-1:0] map_q;
  logic            irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= KS_IDLE;
      row_q   <= '0;
      dwell_q <= '0;
      map_q   <= '0;
      irq_q   <= 1'b0;
    end else if (stop_i) begin
      state_q <= KS_IDLE;
      row_q   <= '0;
      dwell_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      case (state_q)
        KS_IDLE: begin
          if (start_i) begin
            state_q <= KS_SCAN;
            row_q   <= '0;
            dwell_q <= '0;
          end
        end
        KS_SCAN: begin
          if (tick_i) begin
            if (dwell_q == DWELL_LAST) begin
              dwell_q <= '0;
              map_q[int'(row_q)*COLS +: COLS] <= ~col_ni;
              if (row_q == ROW_LAST) begin
                row_q <= '0;
                irq_q <= 1'b1;
              end else begin
                row_q <= row_q + 1'b1;
              end
            end else begin
              dwell_q <= dwell_q + 1'b1;
            end
          end
        end
        default: state_q <= KS_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    assign row_o[i] = (state_q == KS_SCAN) ? (row_q != RW'(i)) : 1'b0;
  end

  assign map_o  = map_q;
  assign irq_o  = irq_q;
  assign idle_o = (state_q == KS_IDLE);
endmodule

// File: rtl/key_map_shift.sv
module key_map_shift #(
  parameter int unsigned KEYS = 30
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            read_i,
  input  logic            sclk_i,
  input  logic [KEYS-1:0] map_i,
  output logic            sdata_o
);
  logic            read_q;
  logic            sclk_q;
  logic [KEYS-1:0] shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      read_q  <= 1'b0;
      sclk_q  <= 1'b0;
      shreg_q <= '0;
    end else begin
      read_q <= read_i;
      sclk_q <= sclk_i;
      if (read_i && !read_q)
        shreg_q <= map_i;
      else if (read_i && sclk_i && !sclk_q)
        shreg_q <= {1'b0, shreg_q[KEYS-1:1]};
    end
  end

  assign sdata_o = shreg_q[0];
endmodule

// File: rtl/key_scan_top.sv
module key_scan_top
  import key_scan_pkg::*;
#(
  parameter int unsigned ROWS       = KS_ROWS,
  parameter int unsigned COLS       = KS_COLS,
  parameter int unsigned HOLD_TICKS = KS_HOLD
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            stop_i,
  input  logic            read_i,
  input  logic            sclk_i,
  input  logic [COLS-1:0] col_ni,
  output logic [ROWS-1:0] row_o,
  output logic            irq_o,
  output logic            sdata_o,
  output logic            sdata_oe_o
);
  localparam int unsigned KEYS = ROWS * COLS;

  logic            idle;
  logic            start;
  logic [KEYS-1:0] map;

  key_change_det #(.COLS(COLS)) u_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .idle_i  (idle),
    .col_ni  (col_ni),
    .start_o (start)
  );

  key_scan_seq #(.ROWS(ROWS), .COLS(COLS), .HOLD_TICKS(HOLD_TICKS)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .start_i (start),
    .stop_i  (stop_i),
    .col_ni  (col_ni),
    .row_o   (row_o),
    .map_o   (map),
    .irq_o   (irq_o),
    .idle_o  (idle)
  );

  key_map_shift #(.KEYS(KEYS)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .read_i  (read_i),
    .sclk_i  (sclk_i),
    .map_i   (map),
    .sdata_o (sdata_o)
  );

  assign sdata_oe_o = read_i;
endmodule

// File: rtl/key_scan_chk.sv
module key_scan_chk #(
  parameter int unsigned ROWS = 5,
  parameter int unsigned COLS = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tick_i,
  input logic            stop_i,
  input logic [COLS-1:0] col_ni,
  input logic [ROWS-1:0] row_o,
  input logic            irq_o
);
  localparam logic [ROWS-1:0] ROW0_LOW = ~ROWS'(1);

  a_r6_one_row_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($countones(~row_o) == 1));

  a_r6_irq_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !stop_i) |=> irq_o);

  a_r7_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> ((row_o == '0) && !irq_o));

  a_r4_rows_need_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !stop_i) |=> $stable(row_o));

  a_r3_scan_starts_row0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_o == '0) |=> ((row_o == '0) || (row_o == ROW0_LOW)));

  logic unused_cols;
  assign unused_cols = ^col_ni;
endmodule

bind key_scan_top key_scan_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .stop_i (stop_i),
  .col_ni (col_ni),
  .row_o  (row_o),
  .irq_o  (irq_o)
);

// File: tb/tb_key_scan_top.sv
module tb_key_scan_top;
  localparam int ROWS = 5;
  localparam int COLS = 6;
  localparam int HOLD = 2;
  localparam int KEYS = ROWS * COLS;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0, stop_i = 1'b0, read_i = 1'b0, sclk_i = 1'b0;
  logic [COLS-1:0] col_ni;
  logic [ROWS-1:0] row_o;
  logic irq_o, sdata_o, sdata_oe_o;
  logic [KEYS-1:0] keys = '0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  key_scan_top #(.ROWS(ROWS), .COLS(COLS), .HOLD_TICKS(HOLD)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .stop_i(stop_i),
    .read_i(read_i), .sclk_i(sclk_i), .col_ni(col_ni), .row_o(row_o),
    .irq_o(irq_o), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o)
  );

  // matrix model: a pressed key on a low row pulls its column low
  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      col_ni[c] = 1'b1;
      for (int r = 0; r < ROWS; r++)
        if (keys[r*COLS+c] && !row_o[r]) col_ni[c] = 1'b0;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_tick();
    tick_i = 1'b1; @(negedge clk); tick_i = 1'b0;
  endtask

  task automatic do_stop();
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
  endtask

  function automatic logic [ROWS-1:0] row_pat(int r);
    return ~(ROWS'(1) << r);
  endfunction

  task automatic read_map(output logic [KEYS-1:0] got, output logic tail);
    read_i = 1'b1;
    @(negedge clk);
    for (int i = 0; i < KEYS; i++) begin
      got[i] = sdata_o;
      sclk_i = 1'b1; @(negedge clk);
      sclk_i = 1'b0; @(negedge clk);
    end
    tail = sdata_o;
  endtask

  task automatic full_pass();
    for (int j = 0; j < ROWS*HOLD; j++) do_tick();
  endtask

  task automatic t_reset();
    chk("R1 rows", 32'(row_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 oe", 32'(sdata_oe_o), 0);
    chk("R1 sdata", 32'(sdata_o), 0);
  endtask

  task automatic t_idle_quiet();
    for (int i = 0; i < 5; i++) do_tick();
    chk("R2 no keys no scan", 32'(row_o), 0);
  endtask

  task automatic t_press_scan();
    keys = '0; keys[1*COLS+2] = 1'b1;
    do_tick();
    chk("R3 press starts at row0", 32'(row_o), 32'(row_pat(0)));
    for (int j = 1; j <= ROWS*HOLD; j++) begin
      do_tick();
      chk("R4 row order", 32'(row_o), 32'(row_pat((j/HOLD)%ROWS)));
      chk("R6 irq timing", 32'(irq_o), (j == ROWS*HOLD) ? 1 : 0);
    end
    // freeze without ticks
    repeat (4) @(negedge clk);
    chk("R4 hold without tick", 32'(row_o), 32'(row_pat(0)));
    full_pass();
    chk("R6 irq sticky", 32'(irq_o), 1);
  endtask

  task automatic t_readout(logic [KEYS-1:0] exp, string tag);
    logic [KEYS-1:0] got;
    logic tail;
    chk("R8 oe low outside read", 32'(sdata_oe_o), 0);
    read_map(got, tail);
    chk("R8 oe high in read", 32'(sdata_oe_o), 1);
    chk(tag, 32'(got), 32'(exp));
    chk("R9 zero after last bit", 32'(tail), 0);
    read_i = 1'b0; @(negedge clk);
    chk("R8 oe released", 32'(sdata_oe_o), 0);
  endtask

  task automatic t_stop_held();
    do_stop();
    chk("R7 stop rows low", 32'(row_o), 0);
    chk("R7 stop irq low", 32'(irq_o), 0);
    for (int i = 0; i < 4; i++) do_tick();
    chk("R2 held key no restart", 32'(row_o), 0);
  endtask

  task automatic t_release();
    keys = '0;
    do_tick();
    chk("R3 release starts scan", 32'(row_o), 32'(row_pat(0)));
    full_pass();
    chk("R6 irq after release pass", 32'(irq_o), 1);
  endtask

  task automatic t_stop_priority();
    tick_i = 1'b1; stop_i = 1'b1; @(negedge clk);
    tick_i = 1'b0; stop_i = 1'b0;
    chk("R7 stop over tick rows", 32'(row_o), 0);
    chk("R7 stop over tick irq", 32'(irq_o), 0);
  endtask

  task automatic t_multi();
    keys = '0;
    keys[0] = 1'b1;                 // row0 col0
    keys[1*COLS+3] = 1'b1;          // row1 col3
    keys[2*COLS+3] = 1'b1;          // row2 col3, same column
    keys[4*COLS+5] = 1'b1;          // row4 col5
    do_tick();
    chk("R3 multi start", 32'(row_o), 32'(row_pat(0)));
    full_pass();
    chk("R6 multi irq", 32'(irq_o), 1);
  endtask

  initial begin
    #(4*150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_quiet();
    t_press_scan();
    t_readout(KEYS'(1) << (1*COLS+2), "R9 single key read, R5 bit 8");
    t_stop_held();
    t_release();
    t_readout('0, "R5 released map zero");
    t_stop_priority();
    t_multi();
    t_readout(keys, "R5 multi key map");
    do_stop();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule